// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the loudness envelope of a single operator in a two-operator FM voice. Each sample tick moves it one step through a rise, a fall to a sustain plateau, an optional slow fade while the key is held, and a release after the key is let go. Its output is an attenuation code in which 0 is full volume and the all-ones code is silence. A key-on event restarts the rise from silence. A key-off event starts the release from wherever the envelope stands.

All step sizes come from 4-bit patch rates combined with a 4-bit rate-scaling key. The key is normally the octave and the top frequency bit of the note. The rise is kept internally as a linear ramp and leaves the block through a logarithmic reshaping curve. If the key is released during the rise, the ramp is converted through that same curve, so the release starts at the loudness that was being heard. Adding the total level, tremolo and waveform lookup is left to the operator that instantiates this block.

Top module: `env_gen`

## Requirements
- R1: After reset the block idles, with the output at 127 (the maximum, mute) and the phase at full scale. Ticks do not change the output until a key-on arrives.
- R2: A key-on clears the 22-bit phase and enters the rise. The first rising tick outputs 127. A key-on has priority over key-off and tick in the same cycle, and it restarts the envelope from any state.
- R3: Rise step: take the effective key k. Let e = min(attackRate + k/4, 15). The step is ((k mod 4)*3 + 12) << (e + 1). attackRate 0 gives a step of 0, and the rise holds at 127. attackRate 15 ends the rise on its first tick.
- R4: The rise ends on the tick where phase + step reaches 2^22, or on any tick when attackRate is 15. On that tick the output and the phase become 0 and the fall begins.
- R5: During the rise, each tick outputs curve(x), where x is the upper 7 bits of the phase before the add. curve(0) = 127. For x > 0, with p = floor(log2 x), curve(x) = 127 - floor((128p + ((x - 2^p)*128 >> p)) / 7).
- R6: Fall, fade and release step: let e = min(rate + k/4, 15). The step is ((k mod 4) + 4) << (e - 1). A rate of 0 gives a step of 0.
- R7: During the fall each tick outputs the upper 7 bits of the phase before the add. When phase + step reaches the level, the phase is set to the level and the fall ends. The level is sustainLevel * 2^18, except that code 15 gives full scale, held as 2^22 - 1. With egSustained = 1 the next state is the plateau, which holds the phase. Otherwise the next state is the fade, which uses releaseRate.
- R8: On the plateau each tick outputs the upper phase bits. Clearing egSustained while on the plateau moves it to the fade.
- R9: The release rate is 5 when susFlag = 1. Otherwise it is 7 when egSustained = 0, and otherwise releaseRate.
- R10: In the fade or the release, a tick where phase + step reaches 2^22 moves to the finished state with output 127. The output then stays at 127 until the next key-on.
- R11: Key-off during the rise sets the phase to curve(upper bits) << 15 and enters the release. Key-off during the fall, plateau or fade enters the release with the phase unchanged. Key-off while idle or finished is ignored.
- R12: The effective key k equals rateKey when ksrSel = 1 and rateKey >> 2 when ksrSel = 0.
- R13: In a cycle with sampleTick low, no state advances the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle strobe per output sample |
| keyOnEvt | input | 1 | Key-on event strobe |
| keyOffEvt | input | 1 | Key-off event strobe |
| attackRate | input | 4 | Rise rate |
| decayRate | input | 4 | Fall rate |
| sustainLevel | input | 4 | Plateau level, 3 dB per code |
| releaseRate | input | 4 | Fade and release rate |
| egSustained | input | 1 | 1: hold at the plateau; 0: fade while keyed |
| ksrSel | input | 1 | Full rate-key scaling when 1 |
| susFlag | input | 1 | Channel sustain: slow release |
| rateKey | input | 4 | Rate-scaling key (octave and top frequency bit) |
| envOut | output | 7 | Attenuation; 0 loud, 127 mute |

## Verification
The hardest case to reach is a key-off that lands partway through the rise. Only then does the phase jump through the log curve to a value that matches no ordinary step count. The bench reaches it by choosing a rise rate slow enough that the key-off falls well inside the ramp. It then follows the whole release against an arithmetic model of the requirements. The other sweeps walk full envelopes through every state edge: a plateau at full scale, a zero fall rate, sustain-flag and percussive release, and a plateau that is left by clearing the envelope-type bit. Each tick of each sweep is compared with the model.

// File: rtl/env_pkg.sv
package env_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SETTLE,
    ST_ATTACK,
    ST_DECAY,
    ST_SUSTAIN,
    ST_RELEASE,
    ST_FINISH
  } envState_t;

  typedef enum logic [1:0] {
    OUT_LIN,
    OUT_CURVE,
    OUT_ZERO,
    OUT_MAX
  } outSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    phaseClr;
    logic    phaseCurve;
    logic    phaseAdd;
    logic    phaseToLevel;
    logic    phaseToFull;
    logic    outLoad;
    outSrc_t outSrc;
  } dpCtl_t;

endpackage

// File: rtl/env_logcurve.sv
module env_logcurve #(
  parameter int W = 7
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int PW = $clog2(W);
  localparam int LW = PW + W;

  logic [PW-1:0] msb;
  logic [W-1:0]  frac;
  logic [LW-1:0] logv;
  logic [W-1:0]  quo;

  // piecewise-linear log2 scaled so that log2(2^W) maps to 2^W
  always_comb begin
    msb = '0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) msb = PW'(i);
    end
    frac = W'(x << (W - int'(msb)));
    logv = {msb, frac};
    quo  = W'(logv / LW'(W));
    y    = (x == '0) ? {W{1'b1}} : ({W{1'b1}} - quo);
  end
endmodule

// File: rtl/env_rate.sv
module env_rate
  import env_pkg::*;
#(
  parameter int PHASE_W = 22
) (
  input  envState_t          state,
  input  logic [3:0]         attackRate,
  input  logic [3:0]         decayRate,
  input  logic [3:0]         releaseRate,
  input  logic               egSustained,
  input  logic               susFlag,
  input  logic               ksrSel,
  input  logic [3:0]         rateKey,
  output logic [PHASE_W-1:0] inc
);
  localparam logic [3:0] RATE_SUS   = 4'd5;
  localparam logic [3:0] RATE_PERC  = 4'd7;
  localparam logic [4:0] ATT_BASE   = 5'd12;
  localparam logic [4:0] ATT_MUL    = 5'd3;
  localparam logic [4:0] DR_BASE    = 5'd4;

  logic [3:0] keyEff, rateSel, effRate;
  logic [4:0] rateSum, mant;
  logic       isAtt;

  always_comb begin
    keyEff  = ksrSel ? rateKey : {2'b00, rateKey[3:2]};
    isAtt   = 1'b0;
    rateSel = 4'd0;
    case (state)
      ST_ATTACK:  begin isAtt = 1'b1; rateSel = attackRate; end
      ST_DECAY:   rateSel = decayRate;
      ST_SUSTAIN: rateSel = releaseRate;
      ST_RELEASE: rateSel = susFlag ? RATE_SUS : (!egSustained ? RATE_PERC : releaseRate);
      default:    rateSel = 4'd0;
    endcase
    rateSum = {1'b0, rateSel} + {3'b000, keyEff[3:2]};
    effRate = (rateSum > 5'd15) ? 4'd15 : rateSum[3:0];
    if (isAtt) begin
      mant = 5'(keyEff[1:0]) * ATT_MUL + ATT_BASE;
      inc  = (rateSel == 4'd0 || rateSel == 4'd15) ? '0
           : PHASE_W'(mant) << ({1'b0, effRate} + 5'd1);
    end else begin
      mant = 5'(keyEff[1:0]) + DR_BASE;
      inc  = (rateSel == 4'd0) ? '0
           : PHASE_W'(mant) << ({1'b0, effRate} - 5'd1);
    end
  end
endmodule

// File: rtl/env_ctrl.sv
module env_ctrl
  import env_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      keyOnEvt,
  input  logic      keyOffEvt,
  input  logic      sampleTick,
  input  logic      egSustained,
  input  logic      attackMax,
  input  logic      sumCarry,
  input  logic      reachLevel,
  output envState_t state,
  output dpCtl_t    ctl
);
  envState_t stateNext;

  always_comb begin
    ctl        = '0;
    ctl.outSrc = OUT_LIN;
    stateNext  = state;
    if (keyOnEvt) begin
      ctl.phaseClr = 1'b1;
      stateNext    = ST_ATTACK;
    end else if (keyOffEvt && (state inside {ST_ATTACK, ST_DECAY, ST_HOLD, ST_SUSTAIN})) begin
      ctl.phaseCurve = (state == ST_ATTACK);
      stateNext      = ST_RELEASE;
    end else if (sampleTick) begin
      ctl.outLoad = 1'b1;
      case (state)
        ST_ATTACK: begin
          if (sumCarry || attackMax) begin
            ctl.phaseClr = 1'b1;
            ctl.outSrc   = OUT_ZERO;
            stateNext    = ST_DECAY;
          end else begin
            ctl.phaseAdd = 1'b1;
            ctl.outSrc   = OUT_CURVE;
          end
        end
        ST_DECAY: begin
          if (reachLevel) begin
            ctl.phaseToLevel = 1'b1;
            stateNext        = egSustained ? ST_HOLD : ST_SUSTAIN;
          end else begin
            ctl.phaseAdd = 1'b1;
          end
        end
        ST_HOLD: begin
          if (!egSustained) stateNext = ST_SUSTAIN;
        end
        ST_SUSTAIN, ST_RELEASE: begin
          if (sumCarry) begin
            ctl.phaseToFull = 1'b1;
            ctl.outSrc      = OUT_MAX;
            stateNext       = ST_FINISH;
          end else begin
            ctl.phaseAdd = 1'b1;
          end
        end
        default: ctl.outSrc = OUT_MAX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/env_datapath.sv
module env_datapath
  import env_pkg::*;
#(
  parameter int PHASE_W = 22,
  parameter int OUT_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [PHASE_W-1:0] inc,
  input  logic [3:0]         slCode,
  output logic [OUT_W-1:0]   envOut,
  output logic               sumCarry,
  output logic               reachLevel
);
  localparam int LOW_W    = PHASE_W - OUT_W;
  localparam int SL_SHIFT = LOW_W + 3;   // 3 dB per level code

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W:0]   sumExt, levelExt;
  logic [OUT_W-1:0]   topBits, curveOut;

  assign topBits  = phase[PHASE_W-1 -: OUT_W];
  assign sumExt   = {1'b0, phase} + {1'b0, inc};
  assign sumCarry = sumExt[PHASE_W];
  assign levelExt = (slCode == 4'hF) ? ((PHASE_W+1)'(1) << PHASE_W)
                                     : ((PHASE_W+1)'(slCode) << SL_SHIFT);
  assign reachLevel = (sumExt >= levelExt);

  env_logcurve #(.W(OUT_W)) u_curve (.x(topBits), .y(curveOut));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '1;
      envOut <= '1;
    end else begin
      if (ctl.phaseClr)          phase <= '0;
      else if (ctl.phaseCurve)   phase <= {curveOut, {LOW_W{1'b0}}};
      else if (ctl.phaseAdd)     phase <= sumExt[PHASE_W-1:0];
      else if (ctl.phaseToLevel) phase <= levelExt[PHASE_W] ? '1 : levelExt[PHASE_W-1:0];
      else if (ctl.phaseToFull)  phase <= '1;
      if (ctl.outLoad) begin
        case (ctl.outSrc)
          OUT_LIN:   envOut <= topBits;
          OUT_CURVE: envOut <= curveOut;
          OUT_ZERO:  envOut <= '0;
          default:   envOut <= '1;
        endcase
      end
    end
  end
endmodule

// File: rtl/env_gen.sv
module env_gen
  import env_pkg::*;
#(
  parameter int PHASE_W = 22,
  parameter int OUT_W   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             keyOnEvt,
  input  logic             keyOffEvt,
  input  logic [3:0]       attackRate,
  input  logic [3:0]       decayRate,
  input  logic [3:0]       sustainLevel,
  input  logic [3:0]       releaseRate,
  input  logic             egSustained,
  input  logic             ksrSel,
  input  logic             susFlag,
  input  logic [3:0]       rateKey,
  output logic [OUT_W-1:0] envOut
);
  envState_t          stateNow;
  dpCtl_t             dpCtl;
  logic [PHASE_W-1:0] incNow;
  logic               sumCarry, reachLevel;

  env_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyOnEvt(keyOnEvt), .keyOffEvt(keyOffEvt),
    .sampleTick(sampleTick), .egSustained(egSustained),
    .attackMax(attackRate == 4'hF), .sumCarry(sumCarry),
    .reachLevel(reachLevel), .state(stateNow), .ctl(dpCtl)
  );

  env_rate #(.PHASE_W(PHASE_W)) u_rate (
    .state(stateNow), .attackRate(attackRate), .decayRate(decayRate),
    .releaseRate(releaseRate), .egSustained(egSustained), .susFlag(susFlag),
    .ksrSel(ksrSel), .rateKey(rateKey), .inc(incNow)
  );

  env_datapath #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .inc(incNow), .slCode(sustainLevel),
    .envOut(envOut), .sumCarry(sumCarry), .reachLevel(reachLevel)
  );
endmodule

// File: rtl/env_gen_chk.sv
module env_gen_chk
  import env_pkg::*;
#(
  parameter int OUT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleTick,
  input logic             keyOnEvt,
  input logic             keyOffEvt,
  input logic [3:0]       attackRate,
  input envState_t        state,
  input logic             sumCarry,
  input logic [OUT_W-1:0] envOut
);
  a_r1_idle_mute: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SETTLE |-> envOut == {OUT_W{1'b1}});

  a_r2_keyon_attack: assert property (@(posedge clk) disable iff (!rstN)
    keyOnEvt |=> state == ST_ATTACK);

  a_r3_zero_rate_stays: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ATTACK && attackRate == 4'd0 && sampleTick && !keyOnEvt && !keyOffEvt)
    |=> state == ST_ATTACK);

  a_r4_attack_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ATTACK && sampleTick && !keyOnEvt && !keyOffEvt &&
     (sumCarry || attackRate == 4'hF))
    |=> (state == ST_DECAY && envOut == '0));

  a_r10_finish_mute: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FINISH |-> envOut == {OUT_W{1'b1}});

  a_r13_no_tick_stable: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(envOut));
endmodule

bind env_gen env_gen_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .keyOnEvt(keyOnEvt),
  .keyOffEvt(keyOffEvt), .attackRate(attackRate), .state(stateNow),
  .sumCarry(sumCarry), .envOut(envOut)
);

// File: tb/sim_env_gen.sv
`timescale 1ns/1ps
module sim_env_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0, keyOnEvt = 1'b0, keyOffEvt = 1'b0;
  logic [3:0] pAr = 0, pDr = 0, pSl = 0, pRr = 0, pKey = 0;
  logic pEg = 0, pKsr = 0, pSus = 0;
  logic [6:0] envOut;

  int nRun = 0, nFail = 0;
  localparam longint FULL = 64'd1 << 22;
  // model: 0 idle 1 rise 2 fall 3 plateau 4 fade 5 release 6 finished
  int mState = 0;
  longint mPhase = FULL - 1;
  int mOut = 127;

  always #2 clk = ~clk;

  env_gen u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .keyOnEvt(keyOnEvt),
    .keyOffEvt(keyOffEvt), .attackRate(pAr), .decayRate(pDr),
    .sustainLevel(pSl), .releaseRate(pRr), .egSustained(pEg), .ksrSel(pKsr),
    .susFlag(pSus), .rateKey(pKey), .envOut(envOut)
  );

  function automatic int curveOf(int x);
    int p;
    if (x == 0) return 127;
    p = 0;
    for (int i = 0; i < 7; i++) if (((x >> i) & 1) == 1) p = i;
    return 127 - (p * 128 + (((x - (1 << p)) * 128) >> p)) / 7;
  endfunction

  function automatic longint riseStep(int r, int k);
    int e;
    if (r == 0 || r == 15) return 0;
    e = r + k / 4; if (e > 15) e = 15;
    return longint'((k % 4) * 3 + 12) << (e + 1);
  endfunction

  function automatic longint fallStep(int r, int k);
    int e;
    if (r == 0) return 0;
    e = r + k / 4; if (e > 15) e = 15;
    return longint'((k % 4) + 4) << (e - 1);
  endfunction

  task automatic modelStep(bit on, bit off, bit tk);
    int k; longint s, lvl; int r; int top;
    k   = pKsr ? int'(pKey) : int'(pKey) / 4;
    top = int'(mPhase >> 15);
    lvl = (pSl == 4'hF) ? FULL : longint'(pSl) << 18;
    if (on) begin
      mState = 1; mPhase = 0;
    end else if (off && (mState >= 1 && mState <= 4)) begin
      if (mState == 1) mPhase = longint'(curveOf(top)) << 15;
      mState = 5;
    end else if (tk) begin
      case (mState)
        1: begin
          s = mPhase + riseStep(int'(pAr), k);
          if (s >= FULL || pAr == 4'hF) begin mOut = 0; mPhase = 0; mState = 2; end
          else begin mOut = curveOf(top); mPhase = s; end
        end
        2: begin
          s = mPhase + fallStep(int'(pDr), k);
          mOut = top;
          if (s >= lvl) begin
            mPhase = (lvl >= FULL) ? FULL - 1 : lvl;
            mState = pEg ? 3 : 4;
          end else mPhase = s;
        end
        3: begin mOut = top; if (!pEg) mState = 4; end
        4, 5: begin
          r = (mState == 4) ? int'(pRr) : (pSus ? 5 : (!pEg ? 7 : int'(pRr)));
          s = mPhase + fallStep(r, k);
          if (s >= FULL) begin mPhase = FULL - 1; mOut = 127; mState = 6; end
          else begin mOut = top; mPhase = s; end
        end
        default: mOut = 127;
      endcase
    end
  endtask

  // drive one cycle, then sample at the following falling edge
  task automatic cyc(bit on, bit off, bit tk);
    keyOnEvt = on; keyOffEvt = off; sampleTick = tk;
    @(negedge clk);
    modelStep(on, off, tk);
    keyOnEvt = 0; keyOffEvt = 0; sampleTick = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runScen(string req, int ar, int dr, int sl, int rr, bit eg,
                         bit ksr, bit sus, int key, int offAt, int flipAt, int steps);
    int bad = 0; int firstAct = 0; int firstExp = 0;
    pAr = 4'(ar); pDr = 4'(dr); pSl = 4'(sl); pRr = 4'(rr);
    pEg = eg; pKsr = ksr; pSus = sus; pKey = 4'(key);
    cyc(1, 0, 0);
    for (int i = 0; i < steps; i++) begin
      if (i == flipAt) pEg = 0;
      cyc(0, i == offAt, 1);
      if (int'(envOut) != mOut) begin
        if (bad == 0) begin firstAct = int'(envOut); firstExp = mOut; end
        bad++;
      end
    end
    nRun++;
    if (bad != 0) begin
      nFail++;
      $display("FAIL %s: %0d ticks differ, first got %0d expected %0d", req, bad, firstAct, firstExp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset output", int'(envOut), 127);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1);
    chk("R1 idle ticks", int'(envOut), 127);
    cyc(0, 1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1);
    chk("R11 key-off while idle ignored", int'(envOut), 127);

    // rise: step 12<<15 per tick, 12 output units
    pAr = 14; pDr = 0; pSl = 5; pRr = 4; pEg = 1; pKsr = 0; pKey = 0; pSus = 0;
    cyc(1, 0, 0);
    cyc(0, 0, 1); chk("R2 first rise tick", int'(envOut), 127);
    cyc(0, 0, 1); chk("R5 curve(12)", int'(envOut), 63);
    cyc(0, 0, 1); chk("R5 curve(24)", int'(envOut), 45);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    chk("R13 no tick holds output", int'(envOut), 45);
    for (int i = 0; i < 7; i++) cyc(0, 0, 1);
    chk("R5 curve(108)", int'(envOut), 5);
    cyc(0, 0, 1); chk("R4 carry ends rise", int'(envOut), 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1);
    chk("R6 zero fall rate holds", int'(envOut), 0);

    pAr = 15; cyc(1, 0, 0); cyc(0, 0, 1);
    chk("R3 rate 15 ends rise at once", int'(envOut), 0);
    pAr = 14; cyc(1, 0, 0); cyc(0, 0, 1);
    chk("R2 retrigger from fall", int'(envOut), 127);

    // R12: full scaling, key 15 -> step 21<<14
    pAr = 10; pKsr = 1; pKey = 15;
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R12 full key scaling", int'(envOut), 68);
    pKsr = 0;
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R12 reduced key scaling", int'(envOut), 127);

    runScen("R4 R5 R7 rise to plateau", 12, 12, 4, 8, 1, 0, 0, 5, -1, -1, 800);
    runScen("R7 R10 fade to finish", 11, 11, 6, 10, 0, 0, 0, 0, -1, -1, 2500);
    runScen("R11 R9 key-off mid rise", 9, 9, 3, 9, 1, 0, 0, 0, 150, -1, 4500);
    runScen("R9 R12 sustain-flag release", 14, 8, 2, 6, 1, 1, 1, 15, 400, -1, 4700);
    runScen("R9 R6 percussive release", 13, 10, 0, 3, 0, 1, 0, 8, 50, -1, 4300);
    runScen("R8 plateau to fade", 12, 12, 3, 11, 1, 0, 0, 4, -1, 300, 900);
    runScen("R7 R3 full-scale plateau", 15, 13, 15, 5, 1, 0, 0, 0, -1, -1, 400);
    chk("R7 plateau at full scale", int'(envOut), 127);
    runScen("R3 zero rise rate", 0, 5, 5, 5, 1, 0, 0, 0, -1, -1, 200);
    runScen("R6 zero fall rate", 12, 0, 5, 5, 1, 0, 0, 0, -1, -1, 300);
    runScen("R10 R11 finished ignores key-off", 12, 12, 3, 12, 0, 0, 0, 12, 700, -1, 800);
    chk("R10 finished stays mute", int'(envOut), 127);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule